// File: doc/BRIEF.md
# Alternating Step Keystream Generator

This block produces a pseudo-random keystream, one bit per requested step, from three linear feedback shift registers of lengths 5, 7 and 9 bits. The short control register advances on every step. Its output bit, taken before it shifts, decides which of the two data registers moves on that step. A 1 moves the 7-bit register and a 0 moves the 9-bit register. The keystream bit is the XOR of the low bits of the two data registers after the step.

A host loads all three seeds in a single cycle with the load strobe. A seed of all zeros would lock its register, so it is replaced by the value 1. After the load, each cycle with the step enable high produces one keystream bit, presented one cycle later together with a one-cycle valid strobe. Cycles without a step leave every register untouched.

Each register keeps its state in bits [LEN-1:0] and emits bit 0. On a shift, the register moves right by one. The new top bit is bit 0 XOR bit TAP. The taps are 2 for the 5-bit register, 1 for the 7-bit register and 4 for the 9-bit register. These give the primitive polynomials x^5+x^2+1, x^7+x+1 and x^9+x^4+1.

Top module: `altstep_keygen`

## Requirements
- R1: A synchronous active-high reset sets every register to all ones and clears ks_bit and ks_valid to 0.
- R2: On every step (step_en high, load low), the 5-bit control register A shifts right. Its new bit 4 is A[0] XOR A[2].
- R3: On a step, the 7-bit register B shifts only when A[0], sampled before A shifts, is 1. Its new bit 6 is B[0] XOR B[1]. Otherwise B holds.
- R4: On a step, the 9-bit register C shifts only when that pre-shift A[0] is 0. Its new bit 8 is C[0] XOR C[4]. Otherwise C holds.
- R5: On the clock edge that performs a step, ks_bit takes B[0] XOR C[0] of the updated registers and ks_valid goes high. ks_valid is high for exactly one cycle per step.
- R6: In a cycle with step_en low and load low, no register changes and ks_valid is low on the following cycle.
- R7: When load is high, all three registers take seed_a, seed_b and seed_c at that edge. Load wins over step_en, and no keystream bit is flagged valid for that cycle.
- R8: A seed of all zeros is stored as the value 1 (bit 0 set, all other bits clear), so no register ever holds zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Write all three seeds this cycle |
| seed_a | input | 5 | Seed for the control register |
| seed_b | input | 7 | Seed for the register moved on a 1 |
| seed_c | input | 9 | Seed for the register moved on a 0 |
| step_en | input | 1 | Advance the generator by one step |
| ks_bit | output | 1 | Keystream bit |
| ks_valid | output | 1 | One-cycle strobe marking a new ks_bit |

## Verification
Two situations are the hardest to reach from the ports. The first is a cycle where load and step_en are both high. The second is a register that has been repaired from a zero seed. The stimulus drives both directly: a load with step_en held high, and seed sets that are all zeros or zero in only one register.

Whether the data registers alternate correctly can only be seen through the keystream. Long runs from several seeds are therefore compared against an independent bit-level model. These runs let the pre-shift control bit take both values many times. Idle gaps are placed between steps so that holding is also exercised.

// File: rtl/ksg_pkg.sv
package ksg_pkg;
  localparam int A_LEN_DEF = 5;
  localparam int A_TAP_DEF = 2;
  localparam int B_LEN_DEF = 7;
  localparam int B_TAP_DEF = 1;
  localparam int C_LEN_DEF = 9;
  localparam int C_TAP_DEF = 4;

  typedef struct packed {
    logic adv_b;
    logic adv_c;
  } adv_t;
endpackage

// File: rtl/ksg_lfsr.sv
module ksg_lfsr #(
  parameter int LEN = 5,
  parameter int TAP = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [LEN-1:0] seed,
  input  logic           shift,
  output logic [LEN-1:0] state,
  output logic [LEN-1:0] state_nxt
);
  localparam logic [LEN-1:0] ONE = {{(LEN-1){1'b0}}, 1'b1};

  logic [LEN-1:0] seed_fixed;
  logic [LEN-1:0] shifted;

  assign seed_fixed = (seed == '0) ? ONE : seed;
  assign shifted    = {state[0] ^ state[TAP], state[LEN-1:1]};

  always_comb begin
    if (load)       state_nxt = seed_fixed;
    else if (shift) state_nxt = shifted;
    else            state_nxt = state;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= '1;
    else     state <= state_nxt;
  end

  p_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!shift && !load) |=> $stable(state));

  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> (state == (($past(seed) == '0) ? ONE : $past(seed))));
endmodule

// File: rtl/ksg_clkctl.sv
module ksg_clkctl
  import ksg_pkg::*;
(
  input  logic sel_bit,
  input  logic step,
  output adv_t adv
);
  always_comb begin
    adv.adv_b = step &  sel_bit;
    adv.adv_c = step & ~sel_bit;
  end
endmodule

// File: rtl/altstep_keygen.sv
module altstep_keygen
  import ksg_pkg::*;
#(
  parameter int A_LEN = A_LEN_DEF,
  parameter int A_TAP = A_TAP_DEF,
  parameter int B_LEN = B_LEN_DEF,
  parameter int B_TAP = B_TAP_DEF,
  parameter int C_LEN = C_LEN_DEF,
  parameter int C_TAP = C_TAP_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [A_LEN-1:0] seed_a,
  input  logic [B_LEN-1:0] seed_b,
  input  logic [C_LEN-1:0] seed_c,
  input  logic             step_en,
  output logic             ks_bit,
  output logic             ks_valid
);
  logic             step;
  adv_t             adv;
  logic [A_LEN-1:0] a_q, a_d;
  logic [B_LEN-1:0] b_q, b_d;
  logic [C_LEN-1:0] c_q, c_d;

  assign step = step_en & ~load;

  ksg_clkctl u_ctl (
    .sel_bit (a_q[0]),
    .step    (step),
    .adv     (adv)
  );

  ksg_lfsr #(.LEN(A_LEN), .TAP(A_TAP)) u_a (
    .clk(clk), .rst(rst), .load(load), .seed(seed_a),
    .shift(step), .state(a_q), .state_nxt(a_d)
  );

  ksg_lfsr #(.LEN(B_LEN), .TAP(B_TAP)) u_b (
    .clk(clk), .rst(rst), .load(load), .seed(seed_b),
    .shift(adv.adv_b), .state(b_q), .state_nxt(b_d)
  );

  ksg_lfsr #(.LEN(C_LEN), .TAP(C_TAP)) u_c (
    .clk(clk), .rst(rst), .load(load), .seed(seed_c),
    .shift(adv.adv_c), .state(c_q), .state_nxt(c_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ks_bit   <= 1'b0;
      ks_valid <= 1'b0;
    end else begin
      ks_valid <= step;
      if (step) ks_bit <= b_d[0] ^ c_d[0];
    end
  end

  p_a_moves_r2: assert property (@(posedge clk) disable iff (rst)
    step |=> !$stable(a_q));

  p_b_sel_r3: assert property (@(posedge clk) disable iff (rst)
    (step && a_q[0]) |=> (!$stable(b_q) && $stable(c_q)));

  p_c_sel_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !a_q[0]) |=> (!$stable(c_q) && $stable(b_q)));

  p_valid_r5: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load) |=> (ks_valid && (ks_bit == (b_q[0] ^ c_q[0]))));

  p_novalid_r6: assert property (@(posedge clk) disable iff (rst)
    !(step_en && !load) |=> !ks_valid);
endmodule

// File: tb/tb_altstep_keygen.sv
module tb_altstep_keygen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [4:0] seed_a = '0;
  logic [6:0] seed_b = '0;
  logic [8:0] seed_c = '0;
  logic       step_en = 1'b0;
  logic       ks_bit;
  logic       ks_valid;

  int total = 0;
  int bad = 0;
  int ma, mb, mc;
  string phase = "R1";
  bit    exp_q[$];
  string tag_q[$];
  bit    done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  altstep_keygen dut (
    .clk(clk), .rst(rst), .load(load), .seed_a(seed_a), .seed_b(seed_b),
    .seed_c(seed_c), .step_en(step_en), .ks_bit(ks_bit), .ks_valid(ks_valid)
  );

  function automatic int nxt(int s, int len, int tap);
    int fb;
    fb = (s ^ (s >> tap)) & 1;
    return (s >> 1) | (fb << (len - 1));
  endfunction

  function automatic int fix(int s);
    return (s == 0) ? 1 : s;
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_step();
    int sel;
    @(negedge clk);
    load = 1'b0;
    step_en = 1'b1;
    sel = ma & 1;
    ma = nxt(ma, 5, 2);
    if (sel == 1) mb = nxt(mb, 7, 1);
    else          mc = nxt(mc, 9, 4);
    exp_q.push_back(bit'((mb ^ mc) & 1));
    tag_q.push_back(phase);
  endtask

  task automatic do_idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      load = 1'b0;
      step_en = 1'b0;
    end
  endtask

  task automatic do_load(int a, int b, int c, bit with_step);
    @(negedge clk);
    load = 1'b1;
    step_en = with_step;
    seed_a = a[4:0];
    seed_b = b[6:0];
    seed_c = c[8:0];
    ma = fix(a);
    mb = fix(b);
    mc = fix(c);
  endtask

  // Monitor: one sample per cycle, 1 time unit after the active edge
  initial begin
    @(posedge clk);
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        if (exp_q.size() > 0) begin
          bit    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " R5 valid"}, int'(ks_valid), 1);
          check({t, " R5 keystream bit"}, int'(ks_bit), int'(e));
        end else begin
          check("R6 R7 no valid without step", int'(ks_valid), 0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    ma = 31; mb = 127; mc = 511;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset ks_valid", int'(ks_valid), 0);
    check("R1 reset ks_bit", int'(ks_bit), 0);

    // R1 R2 R3 R4: run from the reset state
    phase = "R1 R2 R3 R4";
    for (int i = 0; i < 60; i++) do_step();

    // R6: idle gaps between steps must not disturb the sequence
    phase = "R6";
    for (int i = 0; i < 20; i++) begin
      do_step();
      do_idle(1 + (i % 3));
    end

    // R7: plain load, then a long run
    do_load(11, 37, 419, 1'b0);
    phase = "R7 R3 R4";
    for (int i = 0; i < 80; i++) do_step();

    // R7: load while step_en is high; load wins, no valid
    do_load(22, 90, 300, 1'b1);
    phase = "R7";
    for (int i = 0; i < 40; i++) do_step();
    do_idle(2);

    // R8: all seeds zero
    do_load(0, 0, 0, 1'b0);
    phase = "R8";
    for (int i = 0; i < 60; i++) do_step();

    // R8: only one data register seeded with zero
    do_load(5, 0, 77, 1'b0);
    phase = "R8 R3";
    for (int i = 0; i < 50; i++) do_step();
    do_load(19, 101, 0, 1'b0);
    phase = "R8 R4";
    for (int i = 0; i < 50; i++) do_step();
    do_idle(4);

    check("R5 outstanding steps", exp_q.size(), 0);
    done = 1;
    summary();
  end
endmodule